// File: doc/BRIEF.md
# Tick Timer with Shared Watchdog Prescaler

This block combines an 8-bit up-counting timer with a watchdog counter. The two share one programmable prescaler. A control word picks the timer's count source and, when the source is the external pin, which edge counts. It also selects which side owns the prescaler and sets a 3-bit rate. Whichever side does not own the prescaler runs undivided. A timer that advances once per tick is therefore only possible when the prescaler is handed to the watchdog.

When the timer passes from all-ones to zero it raises a sticky overflow flag. Only an explicit clear strobe removes that flag. The watchdog counts instruction-cycle ticks in blocks of `WDT_BASE`. When its divided count completes, it latches a timeout. A clear strobe restarts the watchdog and the shared prescaler together. Software-side code writes the control word, loads or reads the timer, and services both strobes.

Top module: `tick_timer_wdog`

## Requirements
- R1: After reset the timer value is 0, the overflow flag is 0, the watchdog timeout is 0, and the control word is 6'b001000: internal source, rising edge, prescaler owned by the watchdog, rate 0.
- R2: The control word has these fields. Bit 5 selects the count source (1 = external pin). Bit 4 selects the edge (1 = falling). Bit 3 assigns the prescaler (1 = watchdog, 0 = timer). Bits 2:0 hold the rate. With internal source and the prescaler on the watchdog, the timer advances by one for every cycle in which `tick_en` is high. It holds otherwise.
- R3: With external source, `ext_clk` passes through a two-flop synchroniser and then an edge detector. The timer advances once per selected edge, three clock edges after the pin changes.
- R4: With the prescaler assigned to the timer, rate code r lets one timer increment through per 2^(r+1) source events (divide-by-2 up to divide-by-256).
- R5: A timer write loads `tmr_wdata` on the next edge and takes precedence over an increment in the same cycle. When the prescaler is assigned to the timer, the write also clears the prescaler.
- R6: An increment from 8'hFF to 8'h00 sets `ovf_flag`. The flag stays set until `ovf_clr`. If a setting overflow and `ovf_clr` coincide, the flag ends up set.
- R7: The watchdog forms one base event per `WDT_BASE` ticks. With the prescaler on the timer, each base event latches `wdt_timeout`. With the prescaler on the watchdog, rate code r lets one base event in 2^r through. The timeout is sticky.
- R8: `wdt_clr` clears the watchdog count, the shared prescaler and `wdt_timeout`. It wins over a timeout firing in the same cycle.
- R9: A timer write while the prescaler belongs to the watchdog leaves the prescaler untouched, so the watchdog timeout instant does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Instruction-cycle tick strobe |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: source, edge, assignment, rate |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| tmr_rdata | output | 8 | Current timer value |
| ext_clk | input | 1 | External count pin (asynchronous) |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_clr | input | 1 | Watchdog and prescaler clear strobe |
| wdt_timeout | output | 1 | Sticky watchdog timeout |

## Verification
Two pairs of events can land in the same cycle. An overflow increment can coincide with `ovf_clr`, and a timer write can coincide with a pending increment. A directed case parks the timer at 8'hFF and raises a tick together with `ovf_clr`; it then expects the flag to be set and the timer to read zero. The random phases keep write, clear and tick strobes independent, so both collisions recur. Each outcome is judged against a cycle model written from R5 and R6, in which set beats clear and a load beats an increment.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef struct packed {
        logic       src_ext;
        logic       edge_fall;
        logic       pre_to_wdt;
        logic [2:0] rate;
    } tw_ctl_t;

    localparam tw_ctl_t TW_CTL_RESET = '{src_ext: 1'b0, edge_fall: 1'b0,
                                         pre_to_wdt: 1'b1, rate: 3'd0};

endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], din};
        s_d.last  = s_q.chain[STAGES-1];
        rise      = s_q.chain[STAGES-1] & ~s_q.last;
        fall      = ~s_q.chain[STAGES-1] & s_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ev,
    input  logic              to_wdt,
    input  logic [RATE_W-1:0] rate,
    output logic              out
);
    localparam int W = 1 << RATE_W;

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_t;

    pre_t p_d, p_q;
    logic [W-1:0] mask;

    always_comb begin
        // timer side: 2^(rate+1) events; watchdog side: 2^rate events
        mask = {W{1'b1}} >> (W - 1 - int'(rate));
        if (to_wdt) mask = mask >> 1;
        out = ev && ((p_q.cnt & mask) == mask);
        p_d = p_q;
        if (clr)     p_d.cnt = '0;
        else if (ev) p_d.cnt = out ? '0 : p_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
    parameter int BASE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    input  logic fire,
    output logic base_ev,
    output logic timeout
);
    localparam int CW = (BASE > 1) ? $clog2(BASE) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          to;
    } wd_t;

    wd_t w_d, w_q;

    always_comb begin
        base_ev = tick && (w_q.cnt == CW'(BASE - 1));
        w_d     = w_q;
        if (clr)       w_d.cnt = '0;
        else if (tick) w_d.cnt = base_ev ? '0 : w_q.cnt + CW'(1);
        if (clr)       w_d.to = 1'b0;
        else if (fire) w_d.to = 1'b1;
        timeout = w_q.to;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    // R8
    wdt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !timeout);

    // R7
    wdt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(fire));
endmodule

// File: rtl/tick_timer_wdog.sv
module tick_timer_wdog #(
    parameter int TMR_W       = 8,
    parameter int RATE_W      = 3,
    parameter int WDT_BASE    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ctl_we,
    input  logic [5:0]       ctl_wdata,
    input  logic             tmr_we,
    input  logic [TMR_W-1:0] tmr_wdata,
    output logic [TMR_W-1:0] tmr_rdata,
    input  logic             ext_clk,
    input  logic             ovf_clr,
    output logic             ovf_flag,
    input  logic             wdt_clr,
    output logic             wdt_timeout
);
    import tw_pkg::*;

    typedef struct packed {
        tw_ctl_t          ctl;
        logic [TMR_W-1:0] tmr;
        logic             ovf;
    } top_t;

    top_t t_d, t_q;

    logic ext_rise, ext_fall, src_ev, base_ev, pre_in, pre_clr, pre_out;
    logic tmr_inc, wdt_fire;

    tw_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ext_rise), .fall(ext_fall)
    );

    tw_prescaler #(.RATE_W(RATE_W)) i_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .ev(pre_in),
        .to_wdt(t_q.ctl.pre_to_wdt), .rate(t_q.ctl.rate[RATE_W-1:0]), .out(pre_out)
    );

    tw_watchdog #(.BASE(WDT_BASE)) i_wdt (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .clr(wdt_clr),
        .fire(wdt_fire), .base_ev(base_ev), .timeout(wdt_timeout)
    );

    always_comb begin
        src_ev   = t_q.ctl.src_ext ? (t_q.ctl.edge_fall ? ext_fall : ext_rise) : tick_en;
        pre_in   = t_q.ctl.pre_to_wdt ? base_ev : src_ev;
        pre_clr  = wdt_clr | (tmr_we & ~t_q.ctl.pre_to_wdt);
        tmr_inc  = t_q.ctl.pre_to_wdt ? src_ev : pre_out;
        wdt_fire = t_q.ctl.pre_to_wdt ? pre_out : base_ev;

        t_d = t_q;
        if (ctl_we) t_d.ctl = tw_ctl_t'(ctl_wdata);
        if (tmr_we)       t_d.tmr = tmr_wdata;
        else if (tmr_inc) t_d.tmr = t_q.tmr + TMR_W'(1);
        if (tmr_inc && !tmr_we && (t_q.tmr == {TMR_W{1'b1}})) t_d.ovf = 1'b1;
        else if (ovf_clr)                                    t_d.ovf = 1'b0;

        tmr_rdata = t_q.tmr;
        ovf_flag  = t_q.ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.ctl <= TW_CTL_RESET;
            t_q.tmr <= '0;
            t_q.ovf <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    // R5
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_we |=> tmr_rdata == $past(tmr_wdata));

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_inc && !tmr_we && tmr_rdata == {TMR_W{1'b1}}) |=> ovf_flag);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R2
    tmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_we && !tmr_inc) |=> $stable(tmr_rdata));
endmodule

// File: tb/test_tick_timer_wdog.sv
module test_tick_timer_wdog;
    localparam int CLK_PERIOD = 10;
    localparam int WB         = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, ctl_we = 1'b0, tmr_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic [7:0] tmr_wdata = '0;
    logic [7:0] tmr_rdata;
    logic       ext_clk = 1'b0, ovf_clr = 1'b0, wdt_clr = 1'b0;
    logic       ovf_flag, wdt_timeout;

    int checks = 0, errors = 0;
    bit done = 0;

    int   m_tmr, m_base, m_pre;
    bit   m_ovf, m_to, m_s1, m_s2, m_s3;
    logic [5:0] m_ctl;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer_wdog #(.WDT_BASE(WB)) i_tick_timer_wdog (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
        .tmr_rdata(tmr_rdata), .ext_clk(ext_clk), .ovf_clr(ovf_clr),
        .ovf_flag(ovf_flag), .wdt_clr(wdt_clr), .wdt_timeout(wdt_timeout)
    );

    function automatic int pmask(bit to_wdt, int rate);
        return to_wdt ? ((1 << rate) - 1) : ((2 << rate) - 1);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_tmr = 0; m_base = 0; m_pre = 0; m_ovf = 0; m_to = 0;
        m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ctl = 6'b001000;
    endtask

    task automatic model_step();
        bit src, fe, tw, evt, wev, pin, pout, inc, fire;
        int rate, mask;
        src = m_ctl[5]; fe = m_ctl[4]; tw = m_ctl[3]; rate = int'(m_ctl[2:0]);
        evt  = src ? (fe ? (!m_s2 && m_s3) : (m_s2 && !m_s3)) : tick_en;
        wev  = tick_en && (m_base == WB - 1);
        pin  = tw ? wev : evt;
        mask = pmask(tw, rate);
        pout = pin && ((m_pre & mask) == mask);
        inc  = tw ? evt : pout;
        fire = tw ? pout : wev;
        if (!tmr_we && inc && m_tmr == 255) m_ovf = 1;
        else if (ovf_clr)                   m_ovf = 0;
        if (tmr_we)   m_tmr = int'(tmr_wdata);
        else if (inc) m_tmr = (m_tmr + 1) & 255;
        if (wdt_clr || (tmr_we && !tw)) m_pre = 0;
        else if (pin)                   m_pre = pout ? 0 : m_pre + 1;
        if (wdt_clr)      m_base = 0;
        else if (tick_en) m_base = wev ? 0 : m_base + 1;
        if (wdt_clr)   m_to = 0;
        else if (fire) m_to = 1;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
        if (ctl_we) m_ctl = ctl_wdata;
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, int'(tmr_rdata), m_tmr);
        check("R6", int'(ovf_flag), int'(m_ovf));
        check("R7", int'(wdt_timeout), int'(m_to));
        ctl_we = 0; tmr_we = 0; ovf_clr = 0; wdt_clr = 0;
    endtask

    task automatic run_phase(string tag, bit src, bit fe, bit tw, int n, int we_div, int wc_div);
        ctl_we = 1; ctl_wdata = {src, fe, tw, 3'($urandom % 8)};
        tick_en = 0;
        step(tag);
        for (int i = 0; i < n; i++) begin
            tick_en   = ($urandom % 4) != 0;
            if (($urandom % 3) == 0) ext_clk = ~ext_clk;
            tmr_we    = ($urandom % we_div) == 0;
            tmr_wdata = 8'($urandom % 256);
            if (($urandom % 3) == 0) tmr_wdata = 8'hFE;
            ovf_clr   = ($urandom % 30) == 0;
            wdt_clr   = ($urandom % wc_div) == 0;
            step(tag);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 19000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1", int'(tmr_rdata), 0);
        check("R1", int'(ovf_flag), 0);
        check("R1", int'(wdt_timeout), 0);
        // R1 reset control: internal, prescaler on watchdog -> one increment per tick
        tick_en = 1; step("R1");
        check("R1", int'(tmr_rdata), 1);

        // R3 directed: rising edge latency of three edges
        ctl_we = 1; ctl_wdata = 6'b101000; tick_en = 0; step("R3");
        tmr_we = 1; tmr_wdata = 8'h00; step("R3");
        step("R3"); step("R3");
        ext_clk = 1; step("R3"); step("R3");
        check("R3", int'(tmr_rdata), 0);
        step("R3");
        check("R3", int'(tmr_rdata), 1);

        // R4 directed: timer owns prescaler, rate 1 -> divide by 4
        ctl_we = 1; ctl_wdata = 6'b000001; step("R4");
        tmr_we = 1; tmr_wdata = 8'h00; step("R4");
        tick_en = 1;
        repeat (3) step("R4");
        check("R4", int'(tmr_rdata), 0);
        step("R4");
        check("R4", int'(tmr_rdata), 1);

        // R6 directed: overflow set collides with clear strobe; set wins
        ctl_we = 1; ctl_wdata = 6'b001000; tick_en = 0; step("R6");
        tmr_we = 1; tmr_wdata = 8'hFF; step("R6");
        tick_en = 1; ovf_clr = 1; step("R6");
        check("R6", int'(ovf_flag), 1);
        check("R6", int'(tmr_rdata), 0);
        tick_en = 0; ovf_clr = 1; step("R6");
        check("R6", int'(ovf_flag), 0);

        // R7 / R8 directed: timer owns prescaler -> timeout after WB ticks
        ctl_we = 1; ctl_wdata = 6'b000000; step("R7");
        wdt_clr = 1; step("R8");
        check("R8", int'(wdt_timeout), 0);
        tick_en = 1;
        repeat (WB - 1) step("R7");
        check("R7", int'(wdt_timeout), 0);
        step("R7");
        check("R7", int'(wdt_timeout), 1);
        tick_en = 0; wdt_clr = 1; step("R8");
        check("R8", int'(wdt_timeout), 0);

        // random phases checked against the model
        for (int k = 0; k < 3; k++) begin
            run_phase("R2", 0, 0, 1, 2000, 60, 200);
            run_phase("R3", 1, 0, 1, 1500, 60, 200);
            run_phase("R3", 1, 1, 1, 1500, 60, 200);
            run_phase("R4", 0, 0, 0, 2500, 80, 300);
            run_phase("R4", 1, ($urandom % 2) == 1, 0, 1500, 80, 300);
            run_phase("R5", 0, 0, 0, 1500, 6, 300);
            run_phase("R9", 0, 0, 1, 2500, 6, 3000);
            run_phase("R8", 0, 0, 1, 1500, 40, 20);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule